// File: doc/BRIEF.md
# Packed Seconds Counter with Alarm

This block is a real-time counter that advances from a 32.768 kHz tick enable. A prescaler reduces the tick to one increment per second, or it can be switched off so that every tick advances the count. The current time is held as one 32-bit word made of four fields: a day count, hours, minutes and seconds.

Each increment is compared against a stored alarm word. One alarm event fires when only the time of day matches. A second alarm event fires when the day field also matches, so an alarm can be set more than one day ahead. Single-cycle event strobes also mark every second and every minute, hour and day rollover.

A new time word can be loaded at any moment. It is held until the next increment boundary and takes effect there. The alarm word can also be loaded at any moment, and it takes effect at once.

Top module: `sec_alarm_counter`

## Requirements
- R1: After reset, time_o is 0, the alarm word is 0, no load is pending, and evt_o is 0.
- R2: time_o is packed as follows: seconds in bits [5:0], minutes in [11:6], hours in [16:12] and the day count in [31:17]. An increment adds one second to the word.
- R3: While pre_en_i is 0, every cycle with tick_i high is an increment. A cycle with tick_i low leaves time_o unchanged.
- R4: While pre_en_i is 1, an increment happens on every 32768th tick, counted from the last time pre_en_i was low. Any cycle with pre_en_i low clears that tick count.
- R5: A seconds field at 59 or above wraps to 0 and carries into minutes. A minutes field at 59 or above wraps to 0 and carries into hours. An hours field at 23 or above wraps to 0 and carries into the day count, which wraps from 32767 to 0.
- R6: evt_o is a one-cycle strobe vector that is asserted in the same cycle as the time_o update it describes. The bits are: 0x04 on every counting increment, 0x08 when seconds wrap, 0x10 when minutes wrap, and 0x20 when hours wrap (day rollover). Bit 0x01 is always 0.
- R7: The time-of-day alarm bit 0x02 is asserted when bits [16:0] of the incremented time equal bits [16:0] of the alarm word.
- R8: The day alarm bit 0x40 is asserted when all 32 bits of the incremented time equal the alarm word.
- R9: A time load is held pending and replaces time_o at the next increment, with evt_o 0 in that update. A later load overrides an earlier pending one. A load in the same cycle as an increment waits for the following increment.
- R10: An alarm load takes effect immediately and is used by compares from the next increment on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle wide |
| pre_en_i | input | 1 | 1: divide ticks down to 1 Hz; 0: count every tick |
| time_ld_i | input | 1 | Load strobe for the time word |
| time_wd_i | input | 32 | Packed time word to load |
| alarm_ld_i | input | 1 | Load strobe for the alarm word |
| alarm_wd_i | input | 32 | Packed alarm word to load |
| time_o | output | 32 | Current packed time |
| evt_o | output | 7 | Event strobes |

## Verification
The assertions assume that all inputs are synchronous to clk and that tick_i is a plain level sampled on each edge. They take no rollover property for granted, so loaded words with out-of-range fields are allowed. The stimulus changes inputs only on the falling edge. It loads boundary words such as 23:59:50 and day 32767 at 23:59:58, and it drops pre_en_i only in a cycle with tick_i low, so that the prescaler clear can be seen without a stray increment.

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter #(
  parameter int PRE_W = 15,
  parameter int SEC_W = 6,
  parameter int MIN_W = 6,
  parameter int HR_W  = 5,
  parameter int DAY_W = 15
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick_i,
  input  logic                               pre_en_i,
  input  logic                               time_ld_i,
  input  logic [SEC_W+MIN_W+HR_W+DAY_W-1:0] time_wd_i,
  input  logic                               alarm_ld_i,
  input  logic [SEC_W+MIN_W+HR_W+DAY_W-1:0] alarm_wd_i,
  output logic [SEC_W+MIN_W+HR_W+DAY_W-1:0] time_o,
  output logic [6:0]                         evt_o
);
  localparam int TOD_W  = SEC_W + MIN_W + HR_W;
  localparam int TW     = TOD_W + DAY_W;
  localparam int MIN_LO = SEC_W;
  localparam int HR_LO  = SEC_W + MIN_W;
  localparam int DAY_LO = TOD_W;

  logic [PRE_W-1:0] presc;
  logic [TW-1:0]    time_q, pend_q, alarm_q, nxt;
  logic             pv_q;
  logic [6:0]       evt_q;

  wire step = tick_i & (~pre_en_i | (&presc));

  wire [SEC_W-1:0] sec = time_q[0 +: SEC_W];
  wire [MIN_W-1:0] mn  = time_q[MIN_LO +: MIN_W];
  wire [HR_W-1:0]  hr  = time_q[HR_LO +: HR_W];
  wire [DAY_W-1:0] day = time_q[DAY_LO +: DAY_W];

  wire sec_top = sec >= SEC_W'(59);
  wire min_top = mn  >= MIN_W'(59);
  wire hr_top  = hr  >= HR_W'(23);
  wire min_wrap = sec_top & min_top;
  wire hr_wrap  = min_wrap & hr_top;

  assign nxt[0 +: SEC_W]      = sec_top ? '0 : sec + 1'b1;
  assign nxt[MIN_LO +: MIN_W] = sec_top ? (min_top ? '0 : mn + 1'b1) : mn;
  assign nxt[HR_LO +: HR_W]   = min_wrap ? (hr_top ? '0 : hr + 1'b1) : hr;
  assign nxt[DAY_LO +: DAY_W] = hr_wrap ? day + 1'b1 : day;

  always_ff @(posedge clk) begin
    if (!rst_n)              presc <= '0;
    else if (!pre_en_i)      presc <= '0;
    else if (tick_i)         presc <= presc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q  <= '0;
      pend_q  <= '0;
      pv_q    <= 1'b0;
      alarm_q <= '0;
      evt_q   <= '0;
    end else begin
      evt_q <= '0;
      if (step) begin
        if (pv_q) begin
          time_q <= pend_q;
          pv_q   <= 1'b0;
        end else begin
          time_q <= nxt;
          evt_q  <= {nxt == alarm_q, hr_wrap, min_wrap, sec_top, 1'b1,
                     nxt[TOD_W-1:0] == alarm_q[TOD_W-1:0], 1'b0};
        end
      end
      if (time_ld_i) begin
        pend_q <= time_wd_i;
        pv_q   <= 1'b1;
      end
      if (alarm_ld_i) alarm_q <= alarm_wd_i;
    end
  end

  assign time_o = time_q;
  assign evt_o  = evt_q;

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(time_o));
  assert_min_implies_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[3] |-> evt_o[2]);
  assert_day_alarm_implies_tod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[6] |-> evt_o[1]);
  assert_rollover_zero_tod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[5] |-> (time_o[TOD_W-1:0] == '0));
  assert_sec_evt_changes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[2] |-> (time_o != $past(time_o)));
endmodule

// File: tb/sec_alarm_counter_tb_top.sv
module sec_alarm_counter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, pre_en_i = 1'b0, time_ld_i = 1'b0, alarm_ld_i = 1'b0;
  logic [31:0] time_wd_i = '0, alarm_wd_i = '0;
  logic [31:0] time_o;
  logic [6:0]  evt_o;

  sec_alarm_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pre_en_i(pre_en_i),
    .time_ld_i(time_ld_i), .time_wd_i(time_wd_i),
    .alarm_ld_i(alarm_ld_i), .alarm_wd_i(alarm_wd_i),
    .time_o(time_o), .evt_o(evt_o));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit started = 0;
  string req = "R1";

  int m_presc = 0;
  logic [31:0] m_time = 0, m_pend = 0, m_alarm = 0;
  bit m_pv = 0;
  logic [6:0] m_evt = 0;

  function automatic logic [31:0] pack(int d, int h, int m, int s);
    return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  always @(posedge clk) begin
    int s, mi, h, d;
    bit inc, cm, ch, cd;
    cycles++;
    if (!rst_n) begin
      m_presc = 0; m_time = 0; m_pend = 0; m_alarm = 0; m_pv = 0; m_evt = 0;
    end else begin
      inc = tick_i && (!pre_en_i || m_presc == 32767);
      if (!pre_en_i) m_presc = 0;
      else if (tick_i) m_presc = (m_presc + 1) % 32768;
      m_evt = 0;
      if (inc) begin
        if (m_pv) begin
          m_time = m_pend; m_pv = 0;
        end else begin
          s = int'(m_time[5:0]); mi = int'(m_time[11:6]);
          h = int'(m_time[16:12]); d = int'(m_time[31:17]);
          cm = 0; ch = 0; cd = 0;
          if (s >= 59) begin s = 0; cm = 1; end else s++;
          if (cm) begin if (mi >= 59) begin mi = 0; ch = 1; end else mi++; end
          if (ch) begin if (h >= 23) begin h = 0; cd = 1; end else h++; end
          if (cd) d = (d + 1) % 32768;
          m_time = pack(d, h, mi, s);
          m_evt[2] = 1; m_evt[3] = cm; m_evt[4] = ch; m_evt[5] = cd;
          m_evt[1] = (m_time[16:0] == m_alarm[16:0]);
          m_evt[6] = (m_time == m_alarm);
        end
      end
      if (time_ld_i) begin m_pend = time_wd_i; m_pv = 1; end
      if (alarm_ld_i) m_alarm = alarm_wd_i;
    end
    if (cycles > 190000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      tests++;
      if (time_o !== m_time || evt_o !== m_evt) begin
        fails++;
        $display("FAIL %s: time actual=%h expected=%h evt actual=%h expected=%h",
                 req, time_o, m_time, evt_o, m_evt);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ld_time(logic [31:0] w);
    time_ld_i = 1; time_wd_i = w; cyc(1); time_ld_i = 0;
  endtask

  task automatic ld_alarm(logic [31:0] w);
    alarm_ld_i = 1; alarm_wd_i = w; cyc(1); alarm_ld_i = 0;
  endtask

  initial begin
    @(posedge clk); started = 1;
    cyc(3); rst_n = 1; cyc(2);
    req = "R2"; tick_i = 1; cyc(70); tick_i = 0; cyc(2);
    req = "R3";
    for (int i = 0; i < 30; i++) begin tick_i = (i % 3 != 0); cyc(1); end
    tick_i = 0; cyc(3);
    req = "R9"; ld_time(pack(5, 23, 59, 50)); cyc(3);
    ld_time(pack(5, 23, 59, 48)); cyc(2);
    tick_i = 1; cyc(1);
    req = "R5"; cyc(15);
    req = "R9"; ld_time(pack(32767, 23, 59, 58)); cyc(1);
    req = "R5"; cyc(5); tick_i = 0; cyc(1);
    req = "R7"; ld_alarm(pack(9, 0, 0, 5)); ld_time(pack(3, 0, 0, 0));
    tick_i = 1; cyc(10); tick_i = 0;
    req = "R8"; ld_time(pack(9, 0, 0, 0)); tick_i = 1; cyc(10); tick_i = 0;
    req = "R10"; ld_time(pack(9, 0, 0, 0)); tick_i = 1; cyc(2);
    alarm_wd_i = pack(9, 0, 0, 4); alarm_ld_i = 1; cyc(1); alarm_ld_i = 0; cyc(6);
    tick_i = 0; cyc(1);
    req = "R6"; ld_time(pack(1, 0, 0, 63)); tick_i = 1; cyc(4); tick_i = 0; cyc(1);
    req = "R4"; pre_en_i = 1; tick_i = 1; cyc(40000);
    tick_i = 0; pre_en_i = 0; cyc(1); pre_en_i = 1; tick_i = 1; cyc(66000);
    tick_i = 0; cyc(3);
    req = "R1"; rst_n = 0; cyc(2); rst_n = 1; pre_en_i = 0; cyc(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule